// File: doc/BRIEF.md
# Floating-point class test unit

This block inspects one floating-point operand and reports whether it is a NaN, an infinity, a denormal or a zero, and whether it is positive or negative. An eight-entry selector mask names the sign-qualified classes of interest. The answer is a 4-bit condition field, one bit per class group, so it can serve directly as a predicate mask for later conditional work.

Three operand layouts are supported. Double format takes the whole 64-bit word. Single format takes the low 32 bits. A narrow mode, used when the element width is 32 bits, halves single precision and tests a 16-bit half-precision value in the low 16 bits. The selector mask is assembled from a 7-bit immediate field with one extra instruction bit appended below it. The result can pass through one register stage with a valid flag, or it can be combinational, as chosen by a parameter. The default is registered.

Top module: `fp_class_probe`

## Requirements
- R1: With `prec_dbl`=1 the operand is a double: sign at bit 63, exponent at bits 62:52 (all ones is 0x7FF), fraction at bits 51:0. `narrow` has no effect in this mode.
- R2: With `prec_dbl`=0 and `narrow`=0 the operand is a single taken from bits 31:0: sign at bit 31, exponent at 30:23, fraction at 22:0. Bits 63:32 have no effect.
- R3: With `prec_dbl`=0 and `narrow`=1 the operand is a half taken from bits 15:0: sign at bit 15, exponent at 14:10 (all ones is 0x1F), fraction at 9:0. Bits 63:16 have no effect.
- R4: Classes are defined as follows. Infinity has an all-ones exponent and a zero fraction. NaN has an all-ones exponent and a nonzero fraction. Zero has a zero exponent and a zero fraction. Denormal has a zero exponent and a nonzero fraction.
- R5: The selector byte is `m = {sel_imm[6:0], sel_ext}`. Selector k (k = 0..7) is `m[7-k]`, so selector 0 is `sel_imm[6]` and selector 7 is `sel_ext`.
- R6: `cond[3]` is set for a positive NaN when selector 0 is set, or for a negative NaN when selector 1 is set.
- R7: `cond[2]` is set for a positive infinity when selector 2 is set, or for a negative infinity when selector 3 is set.
- R8: `cond[1]` is set for a positive denormal when selector 6 is set, or for a negative denormal when selector 7 is set.
- R9: `cond[0]` is set for a positive zero when selector 4 is set, or for a negative zero when selector 5 is set.
- R10: A normal finite operand gives `cond` = 4'b0000 for any mask.
- R11: An all-zero selector byte gives `cond` = 4'b0000 for any operand.
- R12: With the default registered stage, `out_valid` and `cond` follow the accepted input by exactly one clock. `cond` holds when `in_valid` is low. After reset, `out_valid` is 0 and `cond` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 64 | Floating-point register contents |
| prec_dbl | input | 1 | 1 selects double format, 0 selects single or half |
| narrow | input | 1 | In non-double mode, 1 tests the half-precision value |
| sel_imm | input | 7 | Immediate part of the class selector (upper seven bits) |
| sel_ext | input | 1 | Extra selector bit appended below the immediate |
| out_valid | output | 1 | `cond` carries a new result |
| cond | output | 4 | Condition field {NaN, infinity, denormal, zero} |

## Verification
The hardest case to reach is a selector byte that mixes the two sources. Selectors 6 and 7 split across the immediate and the extra bit, so a swap or an off-by-one in mask assembly only shows up for denormals of one sign. The stimulus therefore drives every special class in both signs, with single-selector masks in which only `sel_ext` is set, or only one immediate bit. It repeats the same classes in single and half layouts with upper operand bits filled with patterns that would change the class if they were read. This exposes a wrong field slice.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;

    localparam int OP_W    = 64;
    localparam int COND_W  = 4;
    localparam int SEL_W   = 8;
    localparam int N_FMT   = 3;

    typedef enum logic [1:0] {
        FMT_DBL  = 2'd0,
        FMT_SGL  = 2'd1,
        FMT_HALF = 2'd2
    } fmt_e;

    typedef struct packed {
        logic neg;
        logic nan;
        logic inf;
        logic den;
        logic zer;
    } fcls_t;

    typedef struct packed {
        logic              valid;
        logic [COND_W-1:0] cond;
    } res_t;

    function automatic int exp_width(input int idx);
        case (idx)
            0:       return 11;
            1:       return 8;
            default: return 5;
        endcase
    endfunction

    function automatic int frac_width(input int idx);
        case (idx)
            0:       return 52;
            1:       return 23;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/fpcls_decode.sv
module fpcls_decode
    import fpcls_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output fcls_t                 cls
);
    localparam int SIGN_POS = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic exp_ones, exp_zero, frac_zero;

    always_comb begin
        exp_f     = word[SIGN_POS-1:FRAC_W];
        frac_f    = word[FRAC_W-1:0];
        exp_ones  = &exp_f;
        exp_zero  = ~|exp_f;
        frac_zero = ~|frac_f;
        cls.neg   = word[SIGN_POS];
        cls.nan   = exp_ones & ~frac_zero;
        cls.inf   = exp_ones &  frac_zero;
        cls.den   = exp_zero & ~frac_zero;
        cls.zer   = exp_zero &  frac_zero;
    end

    always_comb begin
        AST_ONE_CLASS: assert ($onehot0({cls.nan, cls.inf, cls.den, cls.zer})); // R4
    end

endmodule

// File: rtl/fpcls_fmtsel.sv
module fpcls_fmtsel
    import fpcls_pkg::*;
(
    input  logic [OP_W-1:0] operand,
    input  fmt_e            fmt,
    output fcls_t           cls
);
    fcls_t per_fmt [N_FMT];

    for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
        localparam int EW = exp_width(g);
        localparam int FW = frac_width(g);
        fpcls_decode #(
            .EXP_W  (EW),
            .FRAC_W (FW)
        ) u_dec (
            .word (operand[EW+FW:0]),
            .cls  (per_fmt[g])
        );
    end

    always_comb begin
        case (fmt)
            FMT_DBL:  cls = per_fmt[0];
            FMT_SGL:  cls = per_fmt[1];
            default:  cls = per_fmt[2];
        endcase
    end

endmodule

// File: rtl/fpcls_pack.sv
module fpcls_pack
    import fpcls_pkg::*;
(
    input  fcls_t             cls,
    input  logic [SEL_W-1:0]  sel_byte,
    output logic [COND_W-1:0] cond
);
    logic [SEL_W-1:0] sel;

    for (genvar k = 0; k < SEL_W; k++) begin : g_sel
        assign sel[k] = sel_byte[SEL_W-1-k];
    end

    always_comb begin
        cond[3] = cls.nan & (cls.neg ? sel[1] : sel[0]);
        cond[2] = cls.inf & (cls.neg ? sel[3] : sel[2]);
        cond[1] = cls.den & (cls.neg ? sel[7] : sel[6]);
        cond[0] = cls.zer & (cls.neg ? sel[5] : sel[4]);
    end

    always_comb begin
        AST_ZERO_SEL_QUIET: assert (sel_byte != '0 || cond == '0); // R11
        AST_COND_SINGLE:    assert ($onehot0(cond));                // R4
    end

endmodule

// File: rtl/fp_class_probe.sv
module fp_class_probe
    import fpcls_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   operand,
    input  logic              prec_dbl,
    input  logic              narrow,
    input  logic [6:0]        sel_imm,
    input  logic              sel_ext,
    output logic              out_valid,
    output logic [COND_W-1:0] cond
);
    fmt_e              fmt;
    fcls_t             cls;
    logic [SEL_W-1:0]  sel_byte;
    logic [COND_W-1:0] cond_now;
    res_t              res_d, res_q;

    always_comb begin
        if (prec_dbl)    fmt = FMT_DBL;
        else if (narrow) fmt = FMT_HALF;
        else             fmt = FMT_SGL;
        sel_byte = {sel_imm, sel_ext};
    end

    fpcls_fmtsel u_fmtsel (
        .operand (operand),
        .fmt     (fmt),
        .cls     (cls)
    );

    fpcls_pack u_pack (
        .cls      (cls),
        .sel_byte (sel_byte),
        .cond     (cond_now)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) res_d.cond = cond_now;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end

        AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));                                   // R12
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(cond));                                    // R12
        AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sel_imm == '0 && !sel_ext) |=> cond == '0);         // R11
        AST_NORMAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !cls.nan && !cls.inf && !cls.den && !cls.zer)
            |=> cond == '0);                                                 // R10
    end else begin : g_comb
        always_comb begin
            res_q.valid = in_valid;
            res_q.cond  = cond_now;
        end
    end

    assign out_valid = res_q.valid;
    assign cond      = res_q.cond;

endmodule

// File: tb/fp_class_probe_bench.sv
module fp_class_probe_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic        prec_dbl = 1'b0;
    logic        narrow = 1'b0;
    logic [6:0]  sel_imm = '0;
    logic        sel_ext = 1'b0;
    logic        out_valid;
    logic [3:0]  cond;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [4:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    fp_class_probe u_fp_class_probe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .prec_dbl(prec_dbl), .narrow(narrow), .sel_imm(sel_imm),
        .sel_ext(sel_ext), .out_valid(out_valid), .cond(cond)
    );

    function automatic logic [3:0] model(input logic [63:0] op, input logic pd,
                                         input logic nr, input logic [6:0] im,
                                         input logic ex);
        logic [7:0] m;
        logic s, ea, ez, fz;
        logic [3:0] r;
        m = {im, ex};
        if (pd) begin
            s = op[63]; ea = &op[62:52]; ez = ~|op[62:52]; fz = ~|op[51:0];
        end else if (!nr) begin
            s = op[31]; ea = &op[30:23]; ez = ~|op[30:23]; fz = ~|op[22:0];
        end else begin
            s = op[15]; ea = &op[14:10]; ez = ~|op[14:10]; fz = ~|op[9:0];
        end
        r[3] = ea & ~fz & (s ? m[6] : m[7]);
        r[2] = ea &  fz & (s ? m[4] : m[5]);
        r[1] = ez & ~fz & (s ? m[0] : m[1]);
        r[0] = ez &  fz & (s ? m[2] : m[3]);
        return r;
    endfunction

    task automatic drive(input logic v, input logic [63:0] op, input logic pd,
                         input logic nr, input logic [6:0] im, input logic ex,
                         input string tag);
        @(negedge clk);
        in_valid = v; operand = op; prec_dbl = pd; narrow = nr;
        sel_imm = im; sel_ext = ex;
        exp_q.push_back({v, model(op, pd, nr, im, ex)});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        drive(1'b0, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, 1'b0, 7'h7F, 1'b1, "R12 idle");
    endtask

    // Monitor: samples a quarter period after each rising edge
    initial begin
        logic [4:0] e;
        string t;
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (out_valid !== e[4]) begin
                    errors++;
                    $display("FAIL %s out_valid actual %b expected %b", t, out_valid, e[4]);
                end else if (e[4] && cond !== e[3:0]) begin
                    errors++;
                    $display("FAIL %s cond actual %b expected %b", t, cond, e[3:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #5;
        checks++;
        if (out_valid !== 1'b0 || cond !== 4'b0000) begin
            errors++;
            $display("FAIL R12 reset state actual %b/%b expected 0/0000", out_valid, cond);
        end

        // R1 R6 R7 R8 R9: double specials, all selectors on
        drive(1, 64'h7FF8_0000_0000_0000, 1, 0, 7'h7F, 1, "R6 dbl +NaN");
        drive(1, 64'hFFF0_0000_0000_0001, 1, 0, 7'h7F, 1, "R6 dbl -NaN");
        drive(1, 64'h7FF0_0000_0000_0000, 1, 0, 7'h7F, 1, "R7 dbl +inf");
        drive(1, 64'hFFF0_0000_0000_0000, 1, 0, 7'h7F, 1, "R7 dbl -inf");
        drive(1, 64'h0000_0000_0000_0001, 1, 0, 7'h7F, 1, "R8 dbl +den");
        drive(1, 64'h800F_FFFF_FFFF_FFFF, 1, 0, 7'h7F, 1, "R8 dbl -den");
        drive(1, 64'h0000_0000_0000_0000, 1, 0, 7'h7F, 1, "R9 dbl +zero");
        drive(1, 64'h8000_0000_0000_0000, 1, 0, 7'h7F, 1, "R9 dbl -zero");
        drive(1, 64'h3FF0_0000_0000_0000, 1, 0, 7'h7F, 1, "R10 dbl normal");
        // R1: narrow ignored in double mode (low half looks like a half NaN)
        drive(1, 64'h3FF0_0000_0000_7E00, 1, 1, 7'h7F, 1, "R1 narrow ignored");
        drive(1, 64'h0000_0000_7F80_0000, 1, 1, 7'h7F, 1, "R1 narrow ignored den");
        idle();

        // R5: single-selector masks, sign pairing, ext bit only
        for (int k = 0; k < 8; k++) begin
            logic [7:0] mb;
            mb = 8'h80 >> k;
            drive(1, 64'h7FF8_0000_0000_0000, 1, 0, mb[7:1], mb[0], "R5 sel +NaN");
            drive(1, 64'hFFF8_0000_0000_0000, 1, 0, mb[7:1], mb[0], "R5 sel -NaN");
            drive(1, 64'h7FF0_0000_0000_0000, 1, 0, mb[7:1], mb[0], "R5 sel +inf");
            drive(1, 64'hFFF0_0000_0000_0000, 1, 0, mb[7:1], mb[0], "R5 sel -inf");
            drive(1, 64'h0000_0000_0000_0100, 1, 0, mb[7:1], mb[0], "R5 sel +den");
            drive(1, 64'h8000_0000_0000_0100, 1, 0, mb[7:1], mb[0], "R5 sel -den");
            drive(1, 64'h0000_0000_0000_0000, 1, 0, mb[7:1], mb[0], "R5 sel +zero");
            drive(1, 64'h8000_0000_0000_0000, 1, 0, mb[7:1], mb[0], "R5 sel -zero");
        end

        // R2: single, upper word garbage
        drive(1, 64'hFFF0_0000_7FC0_0000, 0, 0, 7'h7F, 1, "R2 sgl +NaN");
        drive(1, 64'h0000_0000_FF80_0000, 0, 0, 7'h7F, 1, "R2 sgl -inf");
        drive(1, 64'h7FF0_0000_0000_0001, 0, 0, 7'h7F, 1, "R2 sgl +den");
        drive(1, 64'h7FF8_0000_8000_0000, 0, 0, 7'h7F, 1, "R2 sgl -zero");
        drive(1, 64'h0000_0000_3F80_0000, 0, 0, 7'h7F, 1, "R2 sgl normal R10");
        drive(1, 64'h0000_0000_807F_FFFF, 0, 0, 7'h00, 1, "R2 sgl -den ext");
        // R3: half, upper bits garbage
        drive(1, 64'h0000_0000_7F80_7E00, 0, 1, 7'h7F, 1, "R3 half +NaN");
        drive(1, 64'h7FF0_0000_0000_FC00, 0, 1, 7'h7F, 1, "R3 half -inf");
        drive(1, 64'hFFFF_FFFF_7F80_0001, 0, 1, 7'h7F, 1, "R3 half +den");
        drive(1, 64'h0000_0000_FF80_8000, 0, 1, 7'h7F, 1, "R3 half -zero");
        drive(1, 64'h0000_0000_0000_3C00, 0, 1, 7'h7F, 1, "R3 half normal R10");
        drive(1, 64'h0000_0000_0000_83FF, 0, 1, 7'h00, 1, "R3 half -den ext");
        idle(); idle();

        // R11: zero mask across formats; R4 class sweep via LFSR
        lf = 64'h1234_5678_9ABC_DEF1;
        for (int i = 0; i < 48; i++) begin
            logic [63:0] op;
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            op = lf;
            case (i % 4)
                0: op[62:52] = '1;
                1: op[30:23] = '0;
                2: op[14:10] = '1;
                default: op[51:0] = '0;
            endcase
            drive(1, op, i[0], i[1], 7'h00, 1'b0, "R11 zero mask");
            drive(1, op, i[0], i[1], lf[6:0], lf[7], "R4 class sweep");
            if (i % 7 == 0) idle();
        end
        idle(); idle();
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #6;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule